// File: doc/BRIEF.md
# Parallel-to-Serial Display Link Transmitter

This block turns a 21-bit pixel word, presented once per pixel clock, into four serial lanes running at seven times the pixel rate. Three lanes carry the word, seven bits per lane per pixel period. The fourth lane carries a forwarded clock pattern that is aligned with the data, so that a receiver can recover both pixel timing and the slot boundaries. The fast serial clock comes from outside the block, for example from a PLL.

The word is captured on the rising pixel-clock edge. A toggle that changes with every capture is synchronised into the serial domain, and its edges become the load strobe for the shift registers. The same strobe feeds a clock-loss monitor. When strobes stop, or when the `awake` input is low, all four lanes are held low and the shift registers are cleared. Output then resumes on a slot boundary. `awake` is synchronised inside the block, so it needs no ordering with the clock or the data. The synchronous reset must be held across several pixel-clock edges so that both clock domains see it.

Top module: `pxl_link_tx`

## Requirements
- R1: Data lane k (k = 0..2) sends word bits 7k+6 down to 7k, most significant first, one bit per serial clock.
- R2: The first bit of a word captured at a pixel-clock rising edge is on the lanes after the third serial-clock rising edge that follows that capture. Words sent at a regular pixel rate follow one another with no gap.
- R3: In every pixel period the clock lane sends 1,1,0,0,0,1,1, and its first bit goes out together with the first data bit.
- R4: Once `awake` is low, all four lanes are low after at most three serial-clock rising edges, and they stay low while `awake` stays low.
- R5: When `awake` returns high while the pixel clock runs, the first complete word captured after the return is sent in full, starting on a slot boundary.
- R6: The link is declared lost after 16 consecutive serial-clock cycles with no load strobe, which is a strobe interval of 17 or more. A strobe interval of 16 or less does not interrupt the output.
- R7: After a loss, and after reset, the lanes stay low for the first three strobes. The word of the fourth strobe is the first one sent.
- R8: During reset all four lanes are low.
- R9: When no new word is loaded after seven bits, the lanes go low until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock; the word is captured on its rising edge |
| ser_clk | input | 1 | Serial bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| pix_data | input | 21 | Parallel pixel word |
| awake | input | 1 | High for normal operation, low for power-down |
| lane_data | output | 3 | Serial data lanes, bit k is lane k |
| lane_clk | output | 1 | Serial forwarded-clock lane |

## Verification
The bench drives the pixel clock one nanosecond after a serial edge, so each capture falls on a known serial edge. From that edge, bit j of a word is due after serial edge 3+j (R2), and a word that is not followed by a load reads zero from edge 10 on. The bench counts serial edges since each pixel rise and samples on the falling serial edge. It takes each expected bit from the word it drove, or from the older word when a new rise came only a few edges earlier. For power-down, one check samples exactly three edges after `awake` falls. Slots that `awake` changes in the middle of are not checked, and every word after that is expected to be either low or complete. For loss and recovery, the bench counts strobe intervals itself and expects low lanes until the fourth strobe of a new run.

// File: rtl/pxl_pkg.sv
`timescale 1ns/1ps
package pxl_pkg;
    localparam int unsigned LANES     = 3;
    localparam int unsigned SLOT_BITS = 7;
    localparam int unsigned WORD_W    = LANES * SLOT_BITS;

    // forwarded-clock slot, leftmost bit sent first
    localparam logic [SLOT_BITS-1:0] CLK_SLOT = 7'b1100011;

    typedef logic [SLOT_BITS-1:0] slot_t;
    typedef logic [WORD_W-1:0]    pix_word_t;

    typedef struct packed {
        slot_t                   fwd_clk;
        slot_t [LANES-1:0]       data;
    } frame_t;

    typedef enum logic {
        LINK_DOWN = 1'b0,
        LINK_UP   = 1'b1
    } link_state_t;

    function automatic frame_t build_frame(input pix_word_t w);
        frame_t f;
        f.fwd_clk = CLK_SLOT;
        for (int k = 0; k < LANES; k++) begin
            f.data[k] = w[k*SLOT_BITS +: SLOT_BITS];
        end
        return f;
    endfunction
endpackage

// File: rtl/pxl_capture.sv
`timescale 1ns/1ps
module pxl_capture
    import pxl_pkg::*;
(
    input  logic      pix_clk,
    input  logic      rst,
    input  pix_word_t pix_in,
    output pix_word_t word_q,
    output logic      word_tgl
);
    // the toggle marks each new capture for the serial domain
    always_ff @(posedge pix_clk) begin
        if (rst) begin
            word_q   <= '0;
            word_tgl <= 1'b0;
        end else begin
            word_q   <= pix_in;
            word_tgl <= ~word_tgl;
        end
    end
endmodule

// File: rtl/pxl_sync_bit.sv
`timescale 1ns/1ps
module pxl_sync_bit #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pxl_link_monitor.sv
`timescale 1ns/1ps
module pxl_link_monitor
    import pxl_pkg::*;
#(
    parameter int unsigned LOSS_LIMIT = 16,
    parameter int unsigned GOOD_NEED  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_s,
    output logic load,
    output logic link_up
);
    localparam int unsigned GAP_W  = $clog2(LOSS_LIMIT + 1);
    localparam int unsigned GOOD_W = $clog2(GOOD_NEED + 1);

    logic              tgl_d;
    logic [GAP_W-1:0]  gap;
    logic [GOOD_W-1:0] good;
    link_state_t       state;
    logic              gap_full;
    logic              gap_last;

    assign load     = tgl_s ^ tgl_d;
    assign gap_full = (gap == GAP_W'(LOSS_LIMIT));
    assign gap_last = (gap == GAP_W'(LOSS_LIMIT - 1));
    assign link_up  = (state == LINK_UP);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_d <= 1'b0;
            gap   <= GAP_W'(LOSS_LIMIT);
            good  <= '0;
            state <= LINK_DOWN;
        end else begin
            tgl_d <= tgl_s;
            if (load)           gap <= '0;
            else if (!gap_full) gap <= gap + 1'b1;

            unique case (state)
                LINK_UP: begin
                    if (!load && gap_last) begin
                        state <= LINK_DOWN;
                        good  <= '0;
                    end
                end
                LINK_DOWN: begin
                    if (load) begin
                        if (gap_full) begin
                            good <= '0;
                        end else if (good == GOOD_W'(GOOD_NEED - 1)) begin
                            state <= LINK_UP;
                            good  <= '0;
                        end else begin
                            good <= good + 1'b1;
                        end
                    end
                end
                default: state <= LINK_DOWN;
            endcase
        end
    end

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

    // R6
    hold_up_chk: assert property (@(posedge clk) disable iff (rst)
        (link_up && load) |=> link_up);

    // R7
    rise_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> $past(load));

    // R6
    gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        gap <= GAP_W'(LOSS_LIMIT));
endmodule

// File: rtl/pxl_serializer.sv
`timescale 1ns/1ps
module pxl_serializer
    import pxl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  frame_t           frame_in,
    output logic [LANES-1:0] dat_o,
    output logic             clk_o
);
    slot_t clk_sr;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            slot_t sr;
            always_ff @(posedge clk) begin
                if (rst || !en)  sr <= '0;
                else if (load)   sr <= frame_in.data[k];
                else             sr <= {sr[SLOT_BITS-2:0], 1'b0};
            end
            assign dat_o[k] = sr[SLOT_BITS-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !en)  clk_sr <= '0;
        else if (load)   clk_sr <= frame_in.fwd_clk;
        else             clk_sr <= {clk_sr[SLOT_BITS-2:0], 1'b0};
    end
    assign clk_o = clk_sr[SLOT_BITS-1];

    // R4
    pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (dat_o == '0 && !clk_o));

    // R3
    clk_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (en && load) |=> clk_o);
endmodule

// File: rtl/pxl_link_tx.sv
`timescale 1ns/1ps
module pxl_link_tx
    import pxl_pkg::*;
#(
    parameter int unsigned LOSS_LIMIT  = 16,
    parameter int unsigned GOOD_NEED   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              pix_clk,
    input  logic              ser_clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] pix_data,
    input  logic              awake,
    output logic [LANES-1:0]  lane_data,
    output logic              lane_clk
);
    pix_word_t word_q;
    logic      word_tgl;
    logic      tgl_s;
    logic      awake_s;
    logic      load;
    logic      link_up;
    logic      ser_en;
    frame_t    frame;

    pxl_capture u_cap (
        .pix_clk  (pix_clk),
        .rst      (rst),
        .pix_in   (pix_data),
        .word_q   (word_q),
        .word_tgl (word_tgl)
    );

    pxl_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tgl_sync (
        .clk (ser_clk),
        .rst (rst),
        .d   (word_tgl),
        .q   (tgl_s)
    );

    pxl_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_awake_sync (
        .clk (ser_clk),
        .rst (rst),
        .d   (awake),
        .q   (awake_s)
    );

    pxl_link_monitor #(.LOSS_LIMIT(LOSS_LIMIT), .GOOD_NEED(GOOD_NEED)) u_mon (
        .clk     (ser_clk),
        .rst     (rst),
        .tgl_s   (tgl_s),
        .load    (load),
        .link_up (link_up)
    );

    // word_q is stable for a full pixel period when the strobe arrives
    assign frame  = build_frame(word_q);
    assign ser_en = awake_s & link_up;

    pxl_serializer u_ser (
        .clk      (ser_clk),
        .rst      (rst),
        .en       (ser_en),
        .load     (load),
        .frame_in (frame),
        .dat_o    (lane_data),
        .clk_o    (lane_clk)
    );
endmodule

// File: tb/pxl_link_tx_test.sv
`timescale 1ns/1ps
module pxl_link_tx_test;
    import pxl_pkg::*;

    localparam logic [6:0] PAT_B = 7'b1100011;

    typedef enum int {M_NONE, M_DATA, M_PD, M_LOST, M_RES, M_GAP} mode_t;

    logic              ser_clk = 1'b0;
    logic              pix_clk = 1'b0;
    logic              rst = 1'b1;
    logic              awake = 1'b1;
    logic [WORD_W-1:0] pix_data = '0;
    logic [LANES-1:0]  lane_data;
    logic              lane_clk;

    int checks = 0;
    int errors = 0;
    int e = 100, ph = 0, hold = 0, hold_req = 0, run_cnt = 0, pd_fe = 100, last_iv = 7;
    logic awake_req = 1'b1, pd_just_up = 1'b0, restart_pend = 1'b1, started = 1'b0;
    logic [WORD_W-1:0] cur_w = '0, prv_w = '0;
    mode_t cur_m = M_LOST, prv_m = M_LOST;

    pxl_link_tx uut (
        .pix_clk   (pix_clk),
        .ser_clk   (ser_clk),
        .rst       (rst),
        .pix_data  (pix_data),
        .awake     (awake),
        .lane_data (lane_data),
        .lane_clk  (lane_clk)
    );

    always #2.5 ser_clk = ~ser_clk;   // 200 MHz serial clock

    function automatic logic [LANES:0] exp_bits(input logic [WORD_W-1:0] w, input int idx);
        logic [LANES:0] r;
        for (int k = 0; k < LANES; k++) r[k] = w[k*7 + idx];
        r[LANES] = PAT_B[idx];
        return r;
    endfunction

    function automatic string tag_of(input mode_t m, input int idx);
        if (m == M_PD)   return "R4";
        if (m == M_LOST) return "R7";
        if (idx < 0)     return "R9";
        if (m == M_RES)  return "R5";
        if (m == M_GAP)  return "R6";
        return "R1 R2 R3";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [LANES:0] got,
                         input logic [LANES:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic on_fall();
        pix_data = WORD_W'($urandom);
        hold = hold_req;
        hold_req = 0;
        if (awake != awake_req) begin
            awake = awake_req;
            cur_m = M_NONE;
            prv_m = M_NONE;
            if (!awake) pd_fe = 0;
            else        pd_just_up = 1'b1;
        end
    endtask

    task automatic on_rise();
        int iv;
        iv = e;
        e = 0;
        last_iv = iv;
        prv_w = cur_w;
        prv_m = cur_m;
        cur_w = pix_data;
        if (rst) begin
            restart_pend = 1'b1;
            run_cnt = 0;
            cur_m = M_LOST;
            prv_m = M_LOST;
        end else begin
            if (restart_pend || iv >= 17) begin
                restart_pend = 1'b0;
                run_cnt = 0;
                if (prv_m != M_NONE) prv_m = M_LOST;
            end
            if (run_cnt < 100) run_cnt++;
            if (!awake)          cur_m = M_PD;
            else if (run_cnt < 4) cur_m = M_LOST;
            else if (pd_just_up) cur_m = M_RES;
            else if (iv > 7)     cur_m = M_GAP;
            else                 cur_m = M_DATA;
            pd_just_up = 1'b0;
        end
    endtask

    // pixel clock: rises 1 ns after a serial edge, period of 7 serial cycles plus holds
    initial begin
        forever begin
            @(posedge ser_clk);
            if (e < 100) e++;
            if (pd_fe < 100) pd_fe++;
            #1;
            if (ph == 6) begin
                if (hold > 0) hold--;
                else begin
                    ph = 0;
                    pix_clk = 1'b1;
                    on_rise();
                end
            end else begin
                ph++;
                if (ph == 3) begin
                    pix_clk = 1'b0;
                    on_fall();
                end
            end
        end
    end

    always @(negedge ser_clk) begin
        mode_t m;
        int idx;
        logic [WORD_W-1:0] w;
        logic [LANES:0] got, exp;
        if (!rst && started) begin
            if (e >= 3) begin m = cur_m; w = cur_w; idx = 9 - e; end
            else        begin m = prv_m; w = prv_w; idx = 9 - (last_iv + e); end
            got = {lane_clk, lane_data};
            if (m != M_NONE) begin
                if (idx < 0 || m == M_PD || m == M_LOST) exp = '0;
                else exp = exp_bits(w, idx);
                check(got == exp, tag_of(m, idx), got, exp);
            end
            // R4: three edges after awake falls, every lane is low
            if (!awake && pd_fe == 3) check(got == '0, "R4", got, '0);
        end
    end

    task automatic wait_periods(input int n);
        repeat (n) @(negedge pix_clk);
    endtask

    initial begin
        void'($urandom(32'd51));
        rst = 1'b1;
        repeat (30) @(negedge ser_clk);
        // R8: lanes low while in reset
        check({lane_clk, lane_data} == '0, "R8", {lane_clk, lane_data}, '0);
        rst = 1'b0;
        started = 1'b1;
        wait_periods(10);          // R7 startup, then R1 R2 R3
        hold_req = 9;              // interval 16: R6 no loss
        wait_periods(5);
        hold_req = 10;             // interval 17: R6 loss, R7 recovery
        wait_periods(8);
        hold_req = 40;             // long stop, R9 zero fill
        wait_periods(8);
        awake_req = 1'b0;          // R4
        wait_periods(5);
        awake_req = 1'b1;          // R5
        wait_periods(6);
        awake_req = 1'b0;
        hold_req = 30;
        wait_periods(6);
        awake_req = 1'b1;
        wait_periods(8);
        for (int i = 0; i < 150; i++) begin
            int r;
            r = $urandom_range(0, 19);
            if (r == 0)      hold_req = $urandom_range(8, 12);
            else if (r == 1) hold_req = $urandom_range(15, 30);
            else if (r == 2) awake_req = ~awake_req;
            wait_periods(1);
        end
        awake_req = 1'b1;
        wait_periods(8);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge ser_clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule